// File: doc/BRIEF.md
# Video-Synchronised Three-Channel Timer

This block holds three 16-bit timer channels. Each channel has a count, a mode and a target register on a small word-addressed register bus. A channel counts ticks of the system clock enable, or of an alternate enable picked by a mode bit. It can reset itself when the count reaches the target, and it raises a one-cycle interrupt pulse on a target match or on a wrap past 0xFFFF.

The mode word also enables a blanking sync mode and selects a 2-bit sync behaviour. Channel 0 follows horizontal blanking and is realigned at each vertical blank. Channel 1 follows vertical blanking. For these two channels the sync behaviours can pause the count during blank or clear it at the start of blank. Channel 2 has no blanking input: in sync mode two of its behaviours freeze the count completely. The blanking inputs are level signals that come from an external video timing generator. The interrupt pulses go to an external interrupt controller.

Top module: `vt_timer`

## Requirements
- R1: Word addresses select the registers. Address bits [5:4] pick the channel (0 to 2) and bits [3:2] pick the register (0 count, 1 mode, 2 target). Bits [1:0] must be zero. Any other address reads 0 and a write to it changes nothing. All three registers are 16 bits wide and read back the value last written.
- R2: When sync mode is off (mode bit 0 = 0), a channel adds 1 on every selected tick and wraps from 0xFFFF to 0.
- R3: Mode bit 8 selects the tick source. For channel 0 it is the pixel enable and for channel 1 the line enable. Channel 2 always uses the system enable, so mode bit 8 has no effect on it.
- R4: On channel 0 or 1, sync mode with behaviour 0 (mode bits [2:1] = 0) holds the count while that channel's blank input is high.
- R5: On channel 0 or 1, sync mode with behaviour 1 or 2 clears the count on the clock edge where the channel's blank input is first seen high. For channel 0 this is horizontal blank, and a rising vertical blank also clears it. For channel 1 it is vertical blank. Behaviour 3 counts freely.
- R6: On channel 2, sync mode with behaviour 0 or 3 freezes the count. Behaviours 1 and 2 count freely.
- R7: When mode bit 3 is set and a tick would make the count equal to the target, the count becomes 0 instead.
- R8: The channel's interrupt output is high for exactly one cycle, the cycle after the edge where the count steps to the target with mode bit 4 set, or wraps from 0xFFFF with mode bit 5 set. It is never high otherwise.
- R9: A count write takes priority over counting and blank clears in the same cycle, and it produces no interrupt.
- R10: After reset, every register reads 0 and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_ce_i | input | 1 | System clock enable tick |
| pix_ce_i | input | 1 | Pixel-rate enable tick, alternate source for channel 0 |
| line_ce_i | input | 1 | Line-rate enable tick, alternate source for channel 1 |
| hblank_i | input | 1 | Horizontal blanking level |
| vblank_i | input | 1 | Vertical blanking level |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| irq_o | output | 3 | Per-channel interrupt pulse |

## Verification
The bench uses the default parameters: a 16-bit count and a 6-bit address. With these, a count written near 0xFFFF reaches overflow within a few ticks, and small targets give frequent matches and target resets. The blank inputs toggle on short periods, so pause, clear and frame realignment happen many times per segment. Random mode words cover every sync behaviour on every channel, together with the alternate tick selection. Stray and unaligned writes exercise the address decode.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    KIND_LINE  = 2'd0,
    KIND_FRAME = 2'd1,
    KIND_STOP  = 2'd2
  } kind_e;

  localparam int unsigned SYNC_B    = 0;
  localparam int unsigned SEL_LSB   = 1;
  localparam int unsigned TGT_RST_B = 3;
  localparam int unsigned TGT_IRQ_B = 4;
  localparam int unsigned OVF_IRQ_B = 5;
  localparam int unsigned ALT_B     = 8;
endpackage

// File: rtl/vt_sync_ctl.sv
module vt_sync_ctl #(
  parameter vt_pkg::kind_e KIND = vt_pkg::KIND_LINE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic [1:0] sel_i,
  input  logic       blank_i,
  input  logic       frame_i,
  output logic       run_o,
  output logic       clr_o
);
  logic blank_q, frame_q;
  logic b_rise, f_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      blank_q <= blank_i;
      frame_q <= frame_i;
    end
  end

  assign b_rise = blank_i & ~blank_q;
  assign f_rise = frame_i & ~frame_q;

  always_comb begin
    run_o = 1'b1;
    clr_o = 1'b0;
    if (sync_i) begin
      if (KIND == vt_pkg::KIND_STOP) begin
        run_o = !(sel_i == 2'd0 || sel_i == 2'd3);
      end else begin
        case (sel_i)
          2'd0:       run_o = !blank_i;
          2'd1, 2'd2: clr_o = b_rise | f_rise;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vt_channel.sv
module vt_channel #(
  parameter vt_pkg::kind_e KIND = vt_pkg::KIND_LINE,
  parameter int unsigned   CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_ce_i,
  input  logic             alt_ce_i,
  input  logic             blank_i,
  input  logic             frame_i,
  input  logic             cnt_we_i,
  input  logic             mode_we_i,
  input  logic             tgt_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mode_o,
  output logic [CNT_W-1:0] tgt_o,
  output logic             irq_o
);
  import vt_pkg::*;

  logic [CNT_W-1:0] cnt_q, mode_q, tgt_q, nxt;
  logic irq_q, tick, run, clr, hit, ovf;

  vt_sync_ctl #(.KIND(KIND)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (mode_q[SYNC_B]),
    .sel_i   (mode_q[SEL_LSB+:2]),
    .blank_i (blank_i),
    .frame_i (frame_i),
    .run_o   (run),
    .clr_o   (clr)
  );

  assign tick = mode_q[ALT_B] ? alt_ce_i : sys_ce_i;
  assign nxt  = cnt_q + 1'b1;
  assign hit  = (nxt == tgt_q);
  assign ovf  = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
      irq_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (run && tick) begin
      cnt_q <= (hit && mode_q[TGT_RST_B]) ? '0 : nxt;
      irq_q <= (hit && mode_q[TGT_IRQ_B]) || (ovf && mode_q[OVF_IRQ_B]);
    end else begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      tgt_q  <= '0;
    end else begin
      if (mode_we_i) mode_q <= wdata_i;
      if (tgt_we_i)  tgt_q  <= wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign tgt_o  = tgt_q;
  assign irq_o  = irq_q;

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(mode_q[TGT_IRQ_B] | mode_q[OVF_IRQ_B]));

  // R5
  blank_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr && !cnt_we_i) |-> cnt_q == '0);

  generate
    if (KIND == KIND_STOP) begin : g_stop_chk
      // R6
      stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(mode_q[SYNC_B] && (mode_q[SEL_LSB+:2] == 2'd0 || mode_q[SEL_LSB+:2] == 2'd3)
              && !cnt_we_i) |-> $stable(cnt_q));
    end else begin : g_pause_chk
      // R4
      pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(mode_q[SYNC_B] && mode_q[SEL_LSB+:2] == 2'd0 && blank_i && !cnt_we_i)
        |-> $stable(cnt_q));
    end
  endgenerate
endmodule

// File: rtl/vt_bus_dec.sv
module vt_bus_dec #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] mode_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] tgt_i,
  output logic [NUM_CH-1:0]            cnt_we_o,
  output logic [NUM_CH-1:0]            mode_we_o,
  output logic [NUM_CH-1:0]            tgt_we_o,
  output logic [CNT_W-1:0]             rdata_o
);
  localparam int unsigned CH_W = ADDR_W - 4;

  logic [CH_W-1:0] ch;
  logic [1:0]      rsel;
  logic            aligned;

  assign ch      = addr_i[ADDR_W-1:4];
  assign rsel    = addr_i[3:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    cnt_we_o  = '0;
    mode_we_o = '0;
    tgt_we_o  = '0;
    rdata_o   = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (aligned && ch == CH_W'(i)) begin
        cnt_we_o[i]  = we_i && rsel == 2'd0;
        mode_we_o[i] = we_i && rsel == 2'd1;
        tgt_we_o[i]  = we_i && rsel == 2'd2;
        case (rsel)
          2'd0:    rdata_o = cnt_i[i];
          2'd1:    rdata_o = mode_i[i];
          2'd2:    rdata_o = tgt_i[i];
          default: rdata_o = '0;
        endcase
      end
    end
  end

  // R1
  one_write_chk: assert final ($countones({cnt_we_o, mode_we_o, tgt_we_o}) <= 1);
endmodule

// File: rtl/vt_timer.sv
module vt_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_ce_i,
  input  logic              pix_ce_i,
  input  logic              line_ce_i,
  input  logic              hblank_i,
  input  logic              vblank_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic [2:0]        irq_o
);
  import vt_pkg::*;

  localparam int unsigned NUM_CH = 3;

  logic [NUM_CH-1:0][CNT_W-1:0] cnt, mode, tgt;
  logic [NUM_CH-1:0] cnt_we, mode_we, tgt_we, alt_ce, blank, frame;

  assign alt_ce = {sys_ce_i, line_ce_i, pix_ce_i};
  assign blank  = {1'b0, vblank_i, hblank_i};
  assign frame  = {1'b0, 1'b0, vblank_i};

  vt_bus_dec #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dec (
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .cnt_i     (cnt),
    .mode_i    (mode),
    .tgt_i     (tgt),
    .cnt_we_o  (cnt_we),
    .mode_we_o (mode_we),
    .tgt_we_o  (tgt_we),
    .rdata_o   (bus_rdata_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam kind_e K = (g == 0) ? KIND_LINE : (g == 1) ? KIND_FRAME : KIND_STOP;
    vt_channel #(.KIND(K), .CNT_W(CNT_W)) i_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sys_ce_i  (sys_ce_i),
      .alt_ce_i  (alt_ce[g]),
      .blank_i   (blank[g]),
      .frame_i   (frame[g]),
      .cnt_we_i  (cnt_we[g]),
      .mode_we_i (mode_we[g]),
      .tgt_we_i  (tgt_we[g]),
      .wdata_i   (bus_wdata_i),
      .cnt_o     (cnt[g]),
      .mode_o    (mode[g]),
      .tgt_o     (tgt[g]),
      .irq_o     (irq_o[g])
    );
  end
endmodule

// File: tb/test_vt_timer.sv
`timescale 1ns/1ps
module test_vt_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_ce = 0, pix_ce = 0, line_ce = 0, hb = 0, vb = 0, we = 0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [2:0]  irq;

  int checks = 0, fails = 0;
  logic [15:0] m_cnt [3], m_mode [3], m_tgt [3];
  logic [2:0]  m_irq = '0;
  logic        m_phb = 0, m_pvb = 0;

  always #10 clk = ~clk;

  vt_timer i_vt_timer (
    .clk_i(clk), .rst_ni(rst_n), .sys_ce_i(sys_ce), .pix_ce_i(pix_ce),
    .line_ce_i(line_ce), .hblank_i(hb), .vblank_i(vb), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] exp_read(input logic [5:0] a);
    if (a[1:0] != 2'b00 || a[5:4] == 2'd3) return 16'h0;
    case (a[3:2])
      2'd0: return m_cnt[a[5:4]];
      2'd1: return m_mode[a[5:4]];
      2'd2: return m_tgt[a[5:4]];
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < 3; c++) begin
      logic tick, blank, brise, frise, run, clr, wr, hit, ovf;
      logic [15:0] nxt;
      logic [1:0] sel;
      tick  = (m_mode[c][8] && c != 2) ? (c == 0 ? pix_ce : line_ce) : sys_ce;
      blank = (c == 0) ? hb : (c == 1) ? vb : 1'b0;
      brise = (c == 0) ? (hb && !m_phb) : (c == 1) ? (vb && !m_pvb) : 1'b0;
      frise = (c == 0) ? (vb && !m_pvb) : 1'b0;
      sel = m_mode[c][2:1];
      run = 1; clr = 0;
      if (m_mode[c][0]) begin
        if (c == 2) run = !(sel == 0 || sel == 3);
        else if (sel == 0) run = !blank;
        else if (sel == 1 || sel == 2) clr = brise || frise;
      end
      wr = we && addr[1:0] == 0 && addr[5:4] == c[1:0];
      m_irq[c] = 1'b0;
      if (wr && addr[3:2] == 0) m_cnt[c] = wdata;
      else if (clr) m_cnt[c] = 16'h0;
      else if (run && tick) begin
        nxt = m_cnt[c] + 16'h1;
        hit = (nxt == m_tgt[c]);
        ovf = (m_cnt[c] == 16'hFFFF);
        m_irq[c] = (hit && m_mode[c][4]) || (ovf && m_mode[c][5]);
        m_cnt[c] = (hit && m_mode[c][3]) ? 16'h0 : nxt;
      end
      if (wr && addr[3:2] == 1) m_mode[c] = wdata;
      if (wr && addr[3:2] == 2) m_tgt[c]  = wdata;
    end
    m_phb = hb; m_pvb = vb;
  endtask

  task automatic step(input string tag, input logic w, input logic [5:0] a, input logic [15:0] d,
                      input logic s, input logic p, input logic l, input logic h, input logic v);
    @(negedge clk);
    we = w; addr = a; wdata = d; sys_ce = s; pix_ce = p; line_ce = l; hb = h; vb = v;
    #1;
    chk({tag, " rdata"}, rdata, exp_read(a));
    chk({tag, " irq"}, {13'h0, irq}, {13'h0, m_irq});
    model_step();
  endtask

  task automatic wr(input string tag, input logic [5:0] a, input logic [15:0] d);
    step(tag, 1'b1, a, d, 1'b0, 1'b0, 1'b0, hb, vb);
  endtask

  task automatic run_n(input string tag, input int n, input logic [5:0] a,
                       input logic s, input logic p, input logic l, input logic h, input logic v);
    for (int i = 0; i < n; i++) step(tag, 1'b0, a, 16'h0, s, p, l, h, v);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int c = 0; c < 3; c++) begin m_cnt[c] = 0; m_mode[c] = 0; m_tgt[c] = 0; end
    seed = $urandom(32'd5713);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state of every register
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 3; r++) step("R10 reset", 0, 6'((c << 4) | (r << 2)), 0, 0, 0, 0, 0, 0);
    // R1: unaligned and channel-3 writes ignored
    wr("R1 stray", 6'h01, 16'h1234);
    wr("R1 stray", 6'h30, 16'h5678);
    wr("R1 mode", 6'h14, 16'hA5C0);
    run_n("R1 mode readback", 1, 6'h14, 0, 0, 0, 0, 0);
    wr("R1 mode", 6'h14, 16'h0000);
    // R2: free run and wrap on channel 2
    wr("R2 cnt", 6'h20, 16'hFFFD);
    run_n("R2 free run wrap", 6, 6'h20, 1, 0, 0, 0, 0);
    // R8: overflow interrupt
    wr("R8 mode", 6'h24, 16'h0020);
    wr("R8 cnt", 6'h20, 16'hFFFE);
    run_n("R8 overflow irq", 4, 6'h20, 1, 0, 0, 0, 0);
    // R7, R8: target reset with target irq on channel 0
    wr("R7 tgt", 6'h08, 16'h0004);
    wr("R7 mode", 6'h04, 16'h0018);
    wr("R7 cnt", 6'h00, 16'h0000);
    run_n("R7 target reset", 12, 6'h00, 1, 0, 0, 0, 0);
    // R3: alternate ticks
    wr("R3 mode0", 6'h04, 16'h0100);
    run_n("R3 pixel tick ch0", 6, 6'h00, 1, 1, 0, 0, 0);
    run_n("R3 sys ignored ch0", 4, 6'h00, 1, 0, 0, 0, 0);
    wr("R3 mode1", 6'h14, 16'h0100);
    run_n("R3 line tick ch1", 5, 6'h10, 1, 0, 1, 0, 0);
    wr("R3 mode2", 6'h24, 16'h0100);
    run_n("R3 ch2 ignores alt", 5, 6'h20, 1, 0, 0, 0, 0);
    // R4: pause during hblank
    wr("R4 mode", 6'h04, 16'h0001);
    run_n("R4 pause", 5, 6'h00, 1, 0, 0, 1, 0);
    run_n("R4 resume", 3, 6'h00, 1, 0, 0, 0, 0);
    // R5: clear on vblank edge ch1, and frame realign ch0
    wr("R5 mode1", 6'h14, 16'h0003);
    run_n("R5 count", 4, 6'h10, 1, 0, 0, 0, 0);
    run_n("R5 vblank clear", 4, 6'h10, 1, 0, 0, 0, 1);
    wr("R5 mode0", 6'h04, 16'h0005);
    run_n("R5 line", 3, 6'h00, 1, 0, 0, 0, 0);
    run_n("R5 hblank clear", 2, 6'h00, 1, 0, 0, 1, 0);
    run_n("R5 frame realign", 3, 6'h00, 1, 0, 0, 0, 1);
    // R6: channel 2 stop
    wr("R6 mode", 6'h24, 16'h0007);
    run_n("R6 stop", 5, 6'h20, 1, 0, 0, 0, 0);
    wr("R6 mode", 6'h24, 16'h0003);
    run_n("R6 free", 3, 6'h20, 1, 0, 0, 0, 0);
    // R9: count write beats blank clear and counting
    wr("R9 mode0", 6'h04, 16'h0003);
    step("R9 write wins", 1, 6'h00, 16'h0042, 1, 0, 0, 1, 0);
    run_n("R9 after", 2, 6'h00, 1, 0, 0, 1, 0);
    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      for (int c = 0; c < 3; c++) begin
        wr("R2,R4,R5,R6 rmode", 6'(c << 4) | 6'h04, 16'($urandom) & 16'h013F);
        wr("R7,R8 rtgt", 6'(c << 4) | 6'h08,
           ($urandom % 4 == 0) ? 16'hFFFF : 16'(3 + $urandom % 30));
        wr("R2,R8 rcnt", 6'(c << 4), ($urandom % 3 == 0) ? 16'(16'hFFF0 + $urandom % 16) : 16'h0);
      end
      for (int i = 0; i < 150; i++) begin
        logic h, v, w;
        h = ((i % 9) < 3);
        v = ((i % 70) < 10);
        w = ($urandom % 25 == 0);
        step("R1,R2,R3,R4,R5,R6,R7,R8,R9 random", w, 6'($urandom),
             w ? 16'($urandom % 64) : 16'h0,
             1'($urandom % 4 != 0), 1'($urandom), 1'($urandom % 3 == 0), h, v);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule